// File: doc/BRIEF.md
# Command-Driven Status Snapshot Queue

This block gathers status words from elsewhere in a line-interface device and places them, tagged by origin, into one shared interrupt queue that a host drains. Entries arrive in two ways. Change strobes from the status sources queue the source's current value by themselves. A write-only command register lets the host force a snapshot of any source, or of a fixed identification word, whether or not anything has changed. Bits in the command register clear themselves once the block has acted on them. One extra bit in that register resets the whole device and puts it into power-down.

All requests are held as pending bits and served one per clock cycle. Pending change-driven requests always win over pending command-driven ones. The queue's read side is a valid/ready stream. `q_valid` is high whenever the queue holds an entry, so it also serves as the not-empty flag. The head entry is removed on a cycle where `q_valid` and `q_ready` are both high. While `q_ready` is low the head entry is held unchanged and nothing is lost on the read side. When the queue fills, new requests are dropped rather than stalled, and a sticky flag records each drop.

Top module: `status_snapshot_queue`

## Requirements
- R1: After reset `q_valid`, `q_overflow`, `pwr_down` and `soft_rst` are all low.
- R2: A command write with a select bit set queues one entry holding the value that the selected source has when the entry is pushed. The entry appears at the output on the cycle after the write, and it is queued even when the value has not changed. Command bit layout: [0] EOC, [1] M4, [2] M56, [3] ACT, [4] STATUS, [5] IDENT, [6] RST. Entry layout: `q_data[15:12]` is the tag and `q_data[11:0]` is the value. Command-driven tags are 9, 10, 11, 12, 13 and 14 for bits 0 through 5.
- R3: When one write sets several select bits, the entries are queued one per cycle in the order EOC, M4, M56, ACT, STATUS, IDENT.
- R4: The IDENT select queues the fixed word {ID_CODE, 8'h08}. With the default ID_CODE of 4'hC this is 12'hC08.
- R5: Command select bits clear themselves. Each write produces exactly one entry per set bit, and after those entries nothing more is queued.
- R6: A change strobe queues the source's current value with a change tag: EOC 1, M4 2, M56 3, ACT 4, STATUS 5. A block-error threshold hit queues `bec_val` with tag 7. Strobes that fire together are served in the order EOC, M4, M56, ACT, STATUS, BEC.
- R7: `eoc_new` is ignored unless `line_sync` is high in the same cycle.
- R8: When a change request and a command request are pending together, the change entry is queued first and the command entry one cycle later.
- R9: With the queue full (DEPTH entries) and no pop in the same cycle, a new entry is dropped. The stored entries are kept, and `q_overflow` goes high and stays high until a reset.
- R10: A write with bit 6 (RST) set does the following. It empties the queue, clears all pending requests and `q_overflow`, and discards the other bits in that write. It pulses `soft_rst` for one cycle and raises `pwr_down`. A later write without RST lowers `pwr_down`.
- R11: While `q_valid` is high and `q_ready` is low, `q_data` holds steady and `q_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 7 | Command bits (layout in R2) |
| line_sync | input | 1 | Line fully active with superframe sync |
| eoc_new | input | 1 | New validated received EOC message |
| m4_chg | input | 1 | M4 overhead bits changed |
| m56_chg | input | 1 | M5/M6 overhead bits changed |
| act_chg | input | 1 | Activation indication changed |
| stat_chg | input | 1 | General status changed |
| bec_hit | input | 1 | Block-error counter reached its threshold |
| rx_eoc | input | 12 | Received EOC word |
| rx_m4 | input | 12 | M4 overhead word |
| rx_m56 | input | 12 | M5/M6 overhead word |
| rx_act | input | 12 | Activation indication word |
| stat_word | input | 12 | General status word |
| bec_val | input | 12 | Block-error counter word |
| q_valid | output | 1 | Queue head valid (queue not empty) |
| q_ready | input | 1 | Host accepts the head entry |
| q_data | output | 16 | Head entry: tag and value |
| q_overflow | output | 1 | Sticky: an entry was dropped |
| pwr_down | output | 1 | Device is in power-down after RST |
| soft_rst | output | 1 | One-cycle device-wide reset pulse |

## Verification
The bench first raises a change strobe and a command write in the same cycle and checks the order of the two entries. A design with the priority reversed, or one that dropped the deferred command, puts the wrong tag first or leaves an entry missing. It writes all six select bits at once, then checks the order and that nothing repeats after the last entry; a select bit that does not clear itself keeps flooding the queue. It fills the queue past DEPTH and checks the held head, the surviving contents and the sticky overflow; a design that overwrites entries or clears the flag early fails here. It also checks that `eoc_new` is gated by `line_sync`, and that a RST write, even one with other bits set, leaves the queue empty.

// File: rtl/snapq_pkg.sv
package snapq_pkg;
  localparam int NSEL    = 6;          // command select sources
  localparam int NCHG    = 6;          // change-driven sources
  localparam int CMD_W   = NSEL + 1;   // select bits plus reset bit
  localparam int RST_BIT = NSEL;
  localparam int TAG_W   = 4;

  typedef enum logic [2:0] {
    SRC_EOC  = 3'd0,
    SRC_M4   = 3'd1,
    SRC_M56  = 3'd2,
    SRC_ACT  = 3'd3,
    SRC_STAT = 3'd4,
    SRC_AUX  = 3'd5   // IDENT for commands, block-error for changes
  } src_e;

  function automatic logic [TAG_W-1:0] cmd_tag(input int idx);
    return TAG_W'(8 + idx + 1);
  endfunction

  function automatic logic [TAG_W-1:0] chg_tag(input int idx);
    if (idx == int'(SRC_AUX)) return TAG_W'(7);
    return TAG_W'(idx + 1);
  endfunction
endpackage

// File: rtl/snapq_cmd_ctrl.sv
module snapq_cmd_ctrl
  import snapq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic [NSEL-1:0]  cmd_grant,
  output logic [NSEL-1:0]  cmd_pend,
  output logic             clr,
  output logic             soft_rst,
  output logic             pwr_down
);
  logic [NSEL-1:0] new_sel;

  assign clr     = cmd_we & cmd_wdata[RST_BIT];
  assign new_sel = cmd_we ? cmd_wdata[NSEL-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pend <= '0;
      soft_rst <= 1'b0;
      pwr_down <= 1'b0;
    end else begin
      soft_rst <= clr;
      if (clr) begin
        cmd_pend <= '0;
        pwr_down <= 1'b1;
      end else begin
        cmd_pend <= (cmd_pend & ~cmd_grant) | new_sel;
        if (cmd_we) pwr_down <= 1'b0;
      end
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !clr |=> !soft_rst); // R10
  AST_RST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cmd_pend == '0) && pwr_down); // R10
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_grant != '0) && !cmd_we |=> (cmd_pend & $past(cmd_grant)) == '0); // R5
endmodule

// File: rtl/snapq_chg_ctrl.sv
module snapq_chg_ctrl
  import snapq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            line_sync,
  input  logic [NCHG-1:0] chg_raw,
  input  logic [NCHG-1:0] chg_grant,
  output logic [NCHG-1:0] chg_pend
);
  logic [NCHG-1:0] chg_set;

  always_comb begin
    chg_set = chg_raw;
    chg_set[SRC_EOC] = chg_raw[SRC_EOC] & line_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chg_pend <= '0;
    else if (clr) chg_pend <= '0;
    else          chg_pend <= (chg_pend & ~chg_grant) | chg_set;
  end

  AST_EOC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    chg_raw[SRC_EOC] && !line_sync && !chg_pend[SRC_EOC] |=> !chg_pend[SRC_EOC]); // R7
endmodule

// File: rtl/snapq_arbiter.sv
module snapq_arbiter
  import snapq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCHG-1:0]               chg_pend,
  input  logic [NSEL-1:0]               cmd_pend,
  input  logic [NCHG-1:0][DATA_W-1:0]   chg_vals,
  input  logic [NSEL-1:0][DATA_W-1:0]   cmd_vals,
  output logic                          push,
  output logic [TAG_W+DATA_W-1:0]       entry,
  output logic [NCHG-1:0]               chg_grant,
  output logic [NSEL-1:0]               cmd_grant
);
  localparam int ENT_W = TAG_W + DATA_W;

  logic [NCHG-1:0][ENT_W-1:0] chg_ent;
  logic [NSEL-1:0][ENT_W-1:0] cmd_ent;

  always_comb begin
    chg_grant = chg_pend & (~chg_pend + NCHG'(1));
    if (chg_pend != '0) cmd_grant = '0;
    else                cmd_grant = cmd_pend & (~cmd_pend + NSEL'(1));
  end

  for (genvar gi = 0; gi < NCHG; gi++) begin : g_chg
    assign chg_ent[gi] = chg_grant[gi] ? {chg_tag(gi), chg_vals[gi]} : '0;
  end
  for (genvar gj = 0; gj < NSEL; gj++) begin : g_cmd
    assign cmd_ent[gj] = cmd_grant[gj] ? {cmd_tag(gj), cmd_vals[gj]} : '0;
  end

  always_comb begin
    entry = '0;
    for (int i = 0; i < NCHG; i++) entry = entry | chg_ent[i];
    for (int j = 0; j < NSEL; j++) entry = entry | cmd_ent[j];
  end

  assign push = (chg_grant != '0) || (cmd_grant != '0);

  AST_CHG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_pend != '0) |-> push && !entry[ENT_W-1]); // R8
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_grant, cmd_grant})); // R3
  AST_SERVE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_pend != '0) || (cmd_pend != '0)) |-> push); // R3
endmodule

// File: rtl/snapq_fifo.sv
module snapq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, pop, accept, drop;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid & out_ready;
  assign accept    = in_valid & (!full | pop);
  assign drop      = in_valid & full & !pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      if (accept && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !accept) cnt <= cnt - CW'(1);
      if (drop) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !clr) mem[wr_ptr] <= in_data;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R9
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !clr |=> full && ovf && $stable(out_data)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> ovf); // R9
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !clr |=> out_valid && $stable(out_data)); // R11
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid && !ovf); // R10
endmodule

// File: rtl/status_snapshot_queue.sv
module status_snapshot_queue
  import snapq_pkg::*;
#(
  parameter int          DATA_W  = 12,
  parameter int          DEPTH   = 8,
  parameter logic [3:0]  ID_CODE = 4'hC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_we,
  input  logic [CMD_W-1:0]        cmd_wdata,
  input  logic                    line_sync,
  input  logic                    eoc_new,
  input  logic                    m4_chg,
  input  logic                    m56_chg,
  input  logic                    act_chg,
  input  logic                    stat_chg,
  input  logic                    bec_hit,
  input  logic [DATA_W-1:0]       rx_eoc,
  input  logic [DATA_W-1:0]       rx_m4,
  input  logic [DATA_W-1:0]       rx_m56,
  input  logic [DATA_W-1:0]       rx_act,
  input  logic [DATA_W-1:0]       stat_word,
  input  logic [DATA_W-1:0]       bec_val,
  output logic                    q_valid,
  input  logic                    q_ready,
  output logic [TAG_W+DATA_W-1:0] q_data,
  output logic                    q_overflow,
  output logic                    pwr_down,
  output logic                    soft_rst
);
  localparam int ENT_W = TAG_W + DATA_W;
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({ID_CODE, 8'h08});

  logic [NSEL-1:0]             cmd_pend, cmd_grant;
  logic [NCHG-1:0]             chg_pend, chg_grant, chg_raw;
  logic [NSEL-1:0][DATA_W-1:0] cmd_vals;
  logic [NCHG-1:0][DATA_W-1:0] chg_vals;
  logic                        clr, push;
  logic [ENT_W-1:0]            entry;

  assign chg_raw  = {bec_hit, stat_chg, act_chg, m56_chg, m4_chg, eoc_new};
  assign cmd_vals = {ID_WORD, stat_word, rx_act, rx_m56, rx_m4, rx_eoc};
  assign chg_vals = {bec_val, stat_word, rx_act, rx_m56, rx_m4, rx_eoc};

  snapq_cmd_ctrl u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_grant(cmd_grant), .cmd_pend(cmd_pend), .clr(clr),
    .soft_rst(soft_rst), .pwr_down(pwr_down)
  );

  snapq_chg_ctrl u_chg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .line_sync(line_sync),
    .chg_raw(chg_raw), .chg_grant(chg_grant), .chg_pend(chg_pend)
  );

  snapq_arbiter #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .chg_pend(chg_pend), .cmd_pend(cmd_pend),
    .chg_vals(chg_vals), .cmd_vals(cmd_vals), .push(push), .entry(entry),
    .chg_grant(chg_grant), .cmd_grant(cmd_grant)
  );

  snapq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(push), .in_data(entry),
    .out_valid(q_valid), .out_ready(q_ready), .out_data(q_data), .ovf(q_overflow)
  );

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !clr && (cmd_wdata[NSEL-1:0] != '0) |=> q_valid || q_overflow || (cmd_pend != '0) || (chg_pend != '0)); // R2
endmodule

// File: tb/test_status_snapshot_queue.sv
module test_status_snapshot_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [6:0]  cmd_wdata = '0;
  logic        line_sync = 1'b1;
  logic        eoc_new = 0, m4_chg = 0, m56_chg = 0, act_chg = 0, stat_chg = 0, bec_hit = 0;
  logic [11:0] rx_eoc = 12'hA01, rx_m4 = 12'hB02, rx_m56 = 12'hC03;
  logic [11:0] rx_act = 12'hD04, stat_word = 12'hE05, bec_val = 12'h0F6;
  logic        q_valid, q_ready = 1'b0, q_overflow, pwr_down, soft_rst;
  logic [15:0] q_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] exp_q [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  status_snapshot_queue #(.DEPTH(DEPTH)) i_status_snapshot_queue (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .line_sync(line_sync), .eoc_new(eoc_new), .m4_chg(m4_chg), .m56_chg(m56_chg),
    .act_chg(act_chg), .stat_chg(stat_chg), .bec_hit(bec_hit),
    .rx_eoc(rx_eoc), .rx_m4(rx_m4), .rx_m56(rx_m56), .rx_act(rx_act),
    .stat_word(stat_word), .bec_val(bec_val), .q_valid(q_valid), .q_ready(q_ready),
    .q_data(q_data), .q_overflow(q_overflow), .pwr_down(pwr_down), .soft_rst(soft_rst)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic write_cmd(input logic [6:0] v);
    cmd_wdata = v; cmd_we = 1'b1;
    step(1);
    cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  // bit order: eoc, m4, m56, act, stat, bec
  task automatic pulse_chg(input logic [5:0] v);
    {bec_hit, stat_chg, act_chg, m56_chg, m4_chg, eoc_new} = v;
    step(1);
    {bec_hit, stat_chg, act_chg, m56_chg, m4_chg, eoc_new} = '0;
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(q_valid === 1'b1, req, {15'd0, q_valid}, 16'd1);
      check(q_data === exp_q[i], req, q_data, exp_q[i]);
      q_ready = 1'b1;
      step(1);
    end
    q_ready = 1'b0;
    check(q_valid === 1'b0, {req, " empty after drain"}, {15'd0, q_valid}, 16'd0);
  endtask

  task automatic t_reset();
    check(q_valid === 1'b0, "R1 q_valid", {15'd0, q_valid}, 16'd0);
    check(q_overflow === 1'b0, "R1 q_overflow", {15'd0, q_overflow}, 16'd0);
    check(pwr_down === 1'b0 && soft_rst === 1'b0, "R1 pwr_down/soft_rst",
          {14'd0, pwr_down, soft_rst}, 16'd0);
  endtask

  task automatic t_single_cmd();
    write_cmd(7'h01);
    check(q_valid === 1'b0, "R2 not yet visible", {15'd0, q_valid}, 16'd0);
    step(1);
    check(q_valid === 1'b1 && q_data === 16'h9A01, "R2 EOC snapshot next cycle", q_data, 16'h9A01);
    write_cmd(7'h01);   // unchanged value, still queued
    step(1);
    exp_q[0] = 16'h9A01; exp_q[1] = 16'h9A01;
    drain(2, "R2 repeat snapshot");
    rx_m4 = 12'h123;
    write_cmd(7'h02);
    step(1);
    exp_q[0] = 16'hA123;
    drain(1, "R2 current M4 value");
    rx_m4 = 12'hB02;
  endtask

  task automatic t_multi_cmd();
    write_cmd(7'h3F);
    step(6);
    exp_q[0] = 16'h9A01; exp_q[1] = 16'hAB02; exp_q[2] = 16'hBC03;
    exp_q[3] = 16'hCD04; exp_q[4] = 16'hDE05; exp_q[5] = 16'hEC08; // R4 ident word
    drain(6, "R3/R4 ordered snapshots");
    step(3);
    check(q_valid === 1'b0, "R5 self-clearing select bits", {15'd0, q_valid}, 16'd0);
  endtask

  task automatic t_changes();
    line_sync = 1'b1;
    pulse_chg(6'b101101); // eoc, m56, act, bec
    step(4);
    exp_q[0] = 16'h1A01; exp_q[1] = 16'h3C03; exp_q[2] = 16'h4D04; exp_q[3] = 16'h70F6;
    drain(4, "R6 change entries");
  endtask

  task automatic t_eoc_gate();
    line_sync = 1'b0;
    pulse_chg(6'b000001);
    step(3);
    check(q_valid === 1'b0, "R7 eoc ignored without sync", {15'd0, q_valid}, 16'd0);
    line_sync = 1'b1;
    pulse_chg(6'b000001);
    step(1);
    exp_q[0] = 16'h1A01;
    drain(1, "R7 eoc accepted with sync");
  endtask

  task automatic t_priority();
    cmd_wdata = 7'h01; cmd_we = 1'b1; m4_chg = 1'b1;
    step(1);
    cmd_we = 1'b0; cmd_wdata = '0; m4_chg = 1'b0;
    step(1);
    check(q_valid === 1'b1 && q_data === 16'h2B02, "R8 change entry first", q_data, 16'h2B02);
    step(1);
    exp_q[0] = 16'h2B02; exp_q[1] = 16'h9A01;
    drain(2, "R8 command deferred one cycle");
  endtask

  task automatic t_overflow();
    logic [15:0] head;
    write_cmd(7'h3F);
    step(6);
    pulse_chg(6'b011010); // m4, act, stat
    step(3);
    check(q_overflow === 1'b1, "R9 overflow flagged", {15'd0, q_overflow}, 16'd1);
    head = q_data;
    step(2);
    check(q_data === head && q_valid === 1'b1, "R11 head held without ready", q_data, head);
    check(q_overflow === 1'b1, "R9 overflow sticky", {15'd0, q_overflow}, 16'd1);
    exp_q[0] = 16'h9A01; exp_q[1] = 16'hAB02; exp_q[2] = 16'hBC03; exp_q[3] = 16'hCD04;
    exp_q[4] = 16'hDE05; exp_q[5] = 16'hEC08; exp_q[6] = 16'h2B02; exp_q[7] = 16'h4D04;
    drain(8, "R9 contents kept, last dropped");
    check(q_overflow === 1'b1, "R9 overflow still set after drain", {15'd0, q_overflow}, 16'd1);
  endtask

  task automatic t_soft_reset();
    write_cmd(7'h03);
    step(2);
    cmd_wdata = 7'h41; cmd_we = 1'b1; // RST with EOC select
    step(1);
    cmd_we = 1'b0; cmd_wdata = '0;
    check(soft_rst === 1'b1 && pwr_down === 1'b1, "R10 pulse and power-down",
          {14'd0, soft_rst, pwr_down}, 16'd3);
    check(q_valid === 1'b0 && q_overflow === 1'b0, "R10 queue and overflow cleared",
          {14'd0, q_valid, q_overflow}, 16'd0);
    step(1);
    check(soft_rst === 1'b0, "R10 pulse one cycle", {15'd0, soft_rst}, 16'd0);
    step(2);
    check(q_valid === 1'b0, "R10 other bits discarded", {15'd0, q_valid}, 16'd0);
    check(pwr_down === 1'b1, "R10 power-down held", {15'd0, pwr_down}, 16'd1);
    write_cmd(7'h10);
    check(pwr_down === 1'b0, "R10 power-down released", {15'd0, pwr_down}, 16'd0);
    step(1);
    exp_q[0] = 16'hDE05;
    drain(1, "R10 normal after release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_single_cmd();
    t_multi_cmd();
    t_changes();
    t_eoc_gate();
    t_priority();
    t_overflow();
    t_soft_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule